// File: doc/BRIEF.md
# Audio Coprocessor Interval Timer Unit

This block holds three independent interval timers for a small audio coprocessor. A clock-enable pulse, `tickEn`, marks each cycle of the 1.024 MHz base clock. Each timer first divides that tick stream by a fixed prescaler. It then counts prescaled steps against an 8-bit period. Each time the count reaches the period, it bumps a 4-bit output counter. Software polls the output counter to learn how many periods have passed since it last looked.

Surrounding logic decodes the processor's I/O space and turns accesses into per-timer strobes: a period write (data on the shared `perData` bus), a counter read and a counter write. The counter value for every timer is always visible on `cntVal`. The read data for a read strobe is the value shown in the same cycle as the strobe. Per-timer enable levels come from the control register outside the block.

Top module: `tmr_unit`

## Requirements
- R1: Timers 0 and 1 advance their internal count once per 128 enabled ticks. Timer 2 advances once per 16 enabled ticks. Prescaling of all three starts from zero when the timer is enabled.
- R2: When an internal step would bring the count to the period, the count returns to 0 and the output counter of that timer rises by one. With period P on timer 2, the counter first reads 1 after exactly 16*P ticks.
- R3: A period value of 0 acts as 256, so timer 2 with period 0 first increments after 4096 ticks.
- R4: The 4-bit output counter wraps from 15 to 0.
- R5: While a counter read strobe is high, `cntVal` shows the value being read. From the next cycle the counter reads 0. The prescaler and internal count are unaffected by the read.
- R6: A counter write strobe clears that counter to 0 from the next cycle, whatever is on the data bus.
- R7: A timer whose enable is low ignores ticks and holds its counter.
- R8: A 0-to-1 change of a timer's enable clears its prescaler, internal count and output counter. After the change, the next increment needs a full prescale interval times the period.
- R9: A period write takes effect from the next cycle. Writing the value already held changes nothing. If the internal count is already at or past a newly written, smaller period, the next internal step wraps the count and increments the counter.
- R10: If a read or write clear and an increment fall in the same cycle, the counter ends at 1. The read returns the value from before the increment.
- R11: A synchronous active-high reset clears all counters to 0 and sets every period to 0, meaning 256. A timer whose enable is high when reset is released is treated as newly enabled.
- R12: Cycles with `tickEn` low do not advance any timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Base-clock tick, one cycle wide |
| enable | input | 3 | Per-timer enable level, bit i gates timer i |
| perWr | input | 3 | Per-timer period write strobe |
| perData | input | 8 | Period value for a period write |
| cntRd | input | 3 | Per-timer counter read strobe (read clears) |
| cntWr | input | 3 | Per-timer counter write strobe (clears) |
| cntVal | output | 12 | Counter of timer i in bits 4i+3 to 4i |

## Verification
An increment takes effect on the clock edge that samples the last tick of a period. It is visible on `cntVal` from that edge on. Read data is the value on `cntVal` while the read strobe is high. Clears, enable restarts and period writes act at the edge that samples the strobe. The bench drives every input just after a falling edge and samples at the next falling edge, so each check falls half a cycle after the edge where the result is due. Tick counts in the checks are exact: each increment is checked one tick before it is due and again on the tick where it is due, which pins down both the prescaler and the period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Strobes the control sends to one timer slice each cycle
  typedef struct packed {
    logic restart;  // enable just went high: clear all state
    logic step;     // one enabled base tick
    logic clear;    // counter read or write access
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                tickEn,
  input  logic [NUM_TIMERS-1:0]               enable,
  input  logic [NUM_TIMERS-1:0]               cntRd,
  input  logic [NUM_TIMERS-1:0]               cntWr,
  output tmrStrobe_t [NUM_TIMERS-1:0]         strobes
);
  logic [NUM_TIMERS-1:0] enPrev;

  always_ff @(posedge clk) begin
    if (rst) enPrev <= '0;
    else     enPrev <= enable;
  end

  always_comb begin
    for (int i = 0; i < NUM_TIMERS; i++) begin
      strobes[i].restart = enable[i] & ~enPrev[i];
      strobes[i].step    = enable[i] & enPrev[i] & tickEn;
      strobes[i].clear   = cntRd[i] | cntWr[i];
    end
  end

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    // R8: a restart lasts one cycle while enable stays high
    p_restart_single_r8: assert property (@(posedge clk) disable iff (rst)
      (strobes[g].restart && enable[g]) |=> !strobes[g].restart)
      else $error("restart held for two cycles");
    // R7: no step on a cycle when the timer is disabled
    p_no_step_disabled_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(enable[g]) |-> !strobes[g].step)
      else $error("step while disabled");
  end
endmodule

// File: rtl/tmr_slice.sv
module tmr_slice
  import tmr_pkg::*;
#(
  parameter int DIV   = 128,
  parameter int PER_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  tmrStrobe_t       strobe,
  input  logic             perWr,
  input  logic [PER_W-1:0] perData,
  output logic [CNT_W-1:0] counter
);
  localparam int PS_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(DIV - 1);

  logic [PS_W-1:0]  pre;
  logic [PER_W-1:0] count;
  logic [PER_W-1:0] period;
  logic [PER_W:0]   effPeriod;
  logic [PER_W:0]   nextCount;
  logic             preWrap;
  logic             wrap;

  always_comb begin
    effPeriod = (period == '0) ? (PER_W+1)'(1 << PER_W) : {1'b0, period};
    nextCount = {1'b0, count} + 1'b1;
    preWrap   = strobe.step && (pre == PS_LAST);
    wrap      = preWrap && (nextCount >= effPeriod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      count   <= '0;
      period  <= '0;
      counter <= '0;
    end else begin
      if (perWr && perData != period) period <= perData;
      if (strobe.restart) begin
        pre     <= '0;
        count   <= '0;
        counter <= '0;
      end else begin
        if (strobe.step) pre <= (pre == PS_LAST) ? '0 : pre + 1'b1;
        if (preWrap)     count <= wrap ? '0 : nextCount[PER_W-1:0];
        if (strobe.clear)  counter <= wrap ? CNT_W'(1) : '0;
        else if (wrap)     counter <= counter + 1'b1;
      end
    end
  end

  // R4: the counter only moves up by one, or drops to 0 or 1 on clear/restart
  p_counter_steps_r4: assert property (@(posedge clk) disable iff (rst)
    (counter != $past(counter)) |->
      (counter == CNT_W'($past(counter) + 1'b1) || counter <= CNT_W'(1)))
    else $error("counter jumped");
  // R12: without a step or restart, prescaler and count hold
  p_idle_holds_r12: assert property (@(posedge clk) disable iff (rst)
    (!strobe.step && !strobe.restart) |=> ($stable(pre) && $stable(count)))
    else $error("timer advanced without a step");
  // R8: restart leaves the whole slice cleared
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.restart |=> (pre == '0 && count == '0 && counter == '0))
    else $error("restart did not clear");
  // R10: a clear leaves at most one pending increment
  p_clear_result_r10: assert property (@(posedge clk) disable iff (rst)
    (strobe.clear && !strobe.restart) |=> counter <= CNT_W'(1))
    else $error("clear left a large counter");
  // R2: a period wrap returns the count to zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (wrap && !strobe.restart) |=> count == '0)
    else $error("count not zero after wrap");
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int PER_W      = 8,
  parameter int CNT_W      = 4,
  parameter int SLOW_DIV   = 128,
  parameter int FAST_DIV   = 16,
  parameter int FAST_IDX   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tickEn,
  input  logic [NUM_TIMERS-1:0]       enable,
  input  logic [NUM_TIMERS-1:0]       perWr,
  input  logic [PER_W-1:0]            perData,
  input  logic [NUM_TIMERS-1:0]       cntRd,
  input  logic [NUM_TIMERS-1:0]       cntWr,
  output logic [NUM_TIMERS*CNT_W-1:0] cntVal
);
  tmrStrobe_t [NUM_TIMERS-1:0] strobes;

  tmr_ctrl #(.NUM_TIMERS(NUM_TIMERS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tickEn (tickEn),
    .enable (enable),
    .cntRd  (cntRd),
    .cntWr  (cntWr),
    .strobes(strobes)
  );

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    localparam int DIV_G = (g == FAST_IDX) ? FAST_DIV : SLOW_DIV;
    tmr_slice #(.DIV(DIV_G), .PER_W(PER_W), .CNT_W(CNT_W)) u_slice (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobes[g]),
      .perWr  (perWr[g]),
      .perData(perData),
      .counter(cntVal[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic [2:0] enable = '0;
  logic [2:0] perWr = '0;
  logic [7:0] perData = '0;
  logic [2:0] cntRd = '0;
  logic [2:0] cntWr = '0;
  logic [11:0] cntVal;

  int errors = 0;
  int checks = 0;

  tmr_unit u0 (
    .clk(clk), .rst(rst), .tickEn(tickEn), .enable(enable),
    .perWr(perWr), .perData(perData), .cntRd(cntRd), .cntWr(cntWr),
    .cntVal(cntVal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int cv(input int idx);
    return int'(cntVal[idx*4 +: 4]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; enable = '0; perWr = '0; cntRd = '0; cntWr = '0; tickEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setPeriod(input int idx, input int val);
    perData = 8'(val); perWr[idx] = 1'b1;
    @(negedge clk);
    perWr = '0;
  endtask

  task automatic setEn(input logic [2:0] mask);
    enable = mask;
    @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic testReset();  // R11, R3
    doReset();
    check("R11 t0 after reset", cv(0), 0);
    check("R11 t1 after reset", cv(1), 0);
    check("R11 t2 after reset", cv(2), 0);
    setEn(3'b100);
    runTicks(4095);
    check("R3 period 256 not yet", cv(2), 0);
    runTicks(1);
    check("R3 period 256 reached", cv(2), 1);
  endtask

  task automatic testPrescale();  // R1
    doReset();
    setPeriod(0, 1); setPeriod(1, 2); setPeriod(2, 1);
    setEn(3'b111);
    runTicks(15);
    check("R1 t2 before 16", cv(2), 0);
    runTicks(1);
    check("R1 t2 at 16", cv(2), 1);
    runTicks(111);
    check("R1 t0 before 128", cv(0), 0);
    runTicks(1);
    check("R1 t0 at 128", cv(0), 1);
    check("R1 t1 period 2 pending", cv(1), 0);
    check("R1 t2 at 128", cv(2), 8);
    runTicks(128);
    check("R1 t0 at 256", cv(0), 2);
    check("R1 t1 at 256", cv(1), 1);
  endtask

  task automatic testPeriod();  // R2
    doReset();
    setPeriod(2, 3); setEn(3'b100);
    runTicks(47);
    check("R2 period 3 before", cv(2), 0);
    runTicks(1);
    check("R2 period 3 first", cv(2), 1);
    runTicks(48);
    check("R2 period 3 second", cv(2), 2);
  endtask

  task automatic testWrap();  // R4
    doReset();
    setPeriod(2, 1); setEn(3'b100);
    runTicks(240);
    check("R4 counter at 15", cv(2), 15);
    runTicks(16);
    check("R4 counter wraps", cv(2), 0);
  endtask

  task automatic testReadClear();  // R5
    doReset();
    setPeriod(2, 1); setEn(3'b100);
    runTicks(48);
    cntRd[2] = 1'b1;
    #1;
    check("R5 read value", cv(2), 3);
    @(negedge clk);
    cntRd = '0;
    check("R5 cleared after read", cv(2), 0);
    runTicks(16);
    check("R5 prescaler kept", cv(2), 1);
  endtask

  task automatic testWriteClear();  // R6
    doReset();
    setPeriod(2, 1); setEn(3'b100);
    runTicks(32);
    perData = 8'hA5;
    cntWr[2] = 1'b1;
    @(negedge clk);
    cntWr = '0;
    check("R6 cleared by write", cv(2), 0);
  endtask

  task automatic testEnable();  // R7, R8, R12
    doReset();
    setPeriod(2, 1); setEn(3'b100);
    runTicks(40);
    check("R12 before idle", cv(2), 2);
    repeat (50) @(negedge clk);
    runTicks(7);
    check("R12 idle cycles ignored", cv(2), 2);
    runTicks(1);
    check("R12 next step lands", cv(2), 3);
    setEn(3'b000);
    runTicks(100);
    check("R7 disabled holds", cv(2), 3);
    setEn(3'b100);
    check("R8 re-enable clears", cv(2), 0);
    runTicks(15);
    check("R8 prescaler restarted", cv(2), 0);
    runTicks(1);
    check("R8 first step after restart", cv(2), 1);
  endtask

  task automatic testPeriodWrite();  // R9
    doReset();
    setPeriod(2, 4); setEn(3'b100);
    runTicks(48);
    check("R9 count 3 of 4", cv(2), 0);
    setPeriod(2, 4);
    runTicks(16);
    check("R9 same value no effect", cv(2), 1);
    runTicks(48);
    setPeriod(2, 2);
    runTicks(15);
    check("R9 smaller period pending", cv(2), 1);
    runTicks(1);
    check("R9 smaller period wraps", cv(2), 2);
    runTicks(32);
    check("R9 new period used", cv(2), 3);
  endtask

  task automatic testCollision();  // R10
    doReset();
    setPeriod(2, 1); setEn(3'b100);
    runTicks(31);
    check("R10 setup", cv(2), 1);
    tickEn = 1'b1;
    cntRd[2] = 1'b1;
    #1;
    check("R10 read returns old value", cv(2), 1);
    @(negedge clk);
    tickEn = 1'b0;
    cntRd = '0;
    check("R10 read and increment", cv(2), 1);
    runTicks(15);
    tickEn = 1'b1;
    cntWr[2] = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    cntWr = '0;
    check("R10 write and increment", cv(2), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testPrescale();
    testPeriod();
    testWrap();
    testReadClear();
    testWriteClear();
    testEnable();
    testPeriodWrite();
    testCollision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule